// File: doc/BRIEF.md
# Protected Processor Mode Control Register

This block holds the byte that sets how a processor core meets its external bus. The byte carries the operating mode, the style of read/write strobes, which address space uses a multiplexed address/data bus, whether four port pins carry address bits or act as general ports, and whether the bus clock is driven out. A separate lock register, at its own address on the same simple synchronous register bus, must have its enable bit set before any write to the mode byte lands. The lock keeps its value until software clears it.

The block refuses settings that must never reach the bus controller. A write that asks for the reserved mode keeps the old mode but applies its other fields. An entire-space multiplexed selection is cleared when the mode that results is microprocessor. Writing 1 to the reset bit raises a one-cycle reset request. At the end of that cycle both registers return to their reset values. The reset value of the mode byte follows a strap input. Reads are combinational and always allowed.

Top module: `pmode_ctrl`

## Requirements
- R1: On synchronous reset the mode byte reads 0x00 when `mode_strap` is low and 0x03 when it is high. The lock register reads 0x00.
- R2: A bus write to MODE_ADDR (default 0x4) changes nothing unless the lock register's bit 1 is 1. A blocked write also raises no reset request.
- R3: The lock register at LOCK_ADDR (default 0xA) stores only bit 1 of a write and reads 0 in all other bits. It keeps its value until written otherwise. Reads of either address return the stored value in the same cycle without a clock edge. Any other address reads 0x00.
- R4: In the mode field, bits 1:0, the encoding is 00 single-chip, 01 memory expansion, 10 reserved and 11 microprocessor. An accepted write with 10 in bits 1:0 leaves the mode field unchanged and still updates bits 2, 4 to 7.
- R5: Bits 5:4 select the multiplexed space: 00 none, 01 second chip-select, 10 first chip-select, 11 entire space. When an accepted write would leave mode 11 together with 11 in bits 5:4, the field is stored as 00 instead. Any other combination is stored as written.
- R6: An accepted write with bit 3 set drives `swreset_o` high for exactly the one cycle that follows. The other bits of that write are discarded, and bit 3 always reads 0. At the edge that ends the pulse, the mode byte takes its R1 reset value from the current `mode_strap` level, and the lock register clears.
- R7: `mode_o`, `strobe_style_o` (bit 2: 0 read/byte-high/write, 1 read/write-high/write-low) and `mux_space_o` show the stored fields. `bclk_oe_o` is the inverse of bit 7.
- R8: `addr_pins_o` is 1 only when the mode is 01 or 11 and bit 6 is 0. It is 0 in single-chip mode whatever bit 6 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap | input | 1 | Strap that picks the mode byte reset value |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| mode_o | output | 2 | Stored operating mode |
| strobe_style_o | output | 1 | Strobe style select |
| mux_space_o | output | 2 | Multiplexed bus space select |
| addr_pins_o | output | 1 | Four shared pins carry address bits |
| bclk_oe_o | output | 1 | Bus clock output enable |
| swreset_o | output | 1 | One-cycle software reset request |

## Verification
An accepted write is visible on `bus_rdata` and the configuration outputs one edge after it is presented. The reset request rises on that same edge, and the restored reset values appear one edge later. After each write, the driver waits one edge plus a small delay and then queues the expected values. The monitor compares them at the following falling edge, so every comparison falls inside the cycle in which its result is due. For the reset pulse, the driver queues the request level and the read-back at the same moment, so both are checked inside the single pulse cycle.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_MPU    = 2'b11
  } mode_e;

  localparam logic [1:0] MUX_NONE = 2'b00;
  localparam logic [1:0] MUX_ALL  = 2'b11;
  localparam int         SWRST_BIT = 3;

  typedef struct packed {
    logic       bclk_off;
    logic       port_fn;
    logic [1:0] mux;
    logic       style;
    mode_e      mode;
  } cfg_t;

  function automatic cfg_t cfg_reset(input logic strap);
    cfg_t c;
    c = '0;
    c.mode = strap ? MODE_MPU : MODE_SINGLE;
    return c;
  endfunction

  function automatic logic [7:0] cfg_pack(input cfg_t c);
    return {c.bclk_off, c.port_fn, c.mux, 1'b0, c.style, c.mode};
  endfunction

  // Apply an accepted write, rejecting the reserved mode and the
  // entire-space multiplexed bus in microprocessor mode.
  function automatic cfg_t cfg_apply(input cfg_t old, input logic [7:0] w);
    cfg_t c;
    c.bclk_off = w[7];
    c.port_fn  = w[6];
    c.style    = w[2];
    c.mode     = (mode_e'(w[1:0]) == MODE_RSVD) ? old.mode : mode_e'(w[1:0]);
    c.mux      = ((c.mode == MODE_MPU) && (w[5:4] == MUX_ALL)) ? MUX_NONE : w[5:4];
    return c;
  endfunction

endpackage

// File: rtl/pmode_wr_decode.sv
module pmode_wr_decode #(
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(10)
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_mode,
  output logic              wr_lock,
  output logic              hit_mode,
  output logic              hit_lock
);
  always_comb begin
    hit_mode = (bus_addr == MODE_ADDR);
    hit_lock = (bus_addr == LOCK_ADDR);
    wr_mode  = bus_sel && bus_we && hit_mode;
    wr_lock  = bus_sel && bus_we && hit_lock;
  end
endmodule

// File: rtl/pmode_field_regs.sv
module pmode_field_regs
  import pmode_pkg::*;
#(
  parameter int LOCK_BIT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_strap,
  input  logic       wr_mode,
  input  logic       wr_lock,
  input  logic [7:0] wdata,
  output cfg_t       cfg_q,
  output logic       lock_q,
  output logic       swrst_q
);
  logic accept;
  assign accept = wr_mode && lock_q && !swrst_q;

  always_ff @(posedge clk) begin
    if (rst || swrst_q) begin
      cfg_q   <= cfg_reset(mode_strap);
      lock_q  <= 1'b0;
      swrst_q <= 1'b0;
    end else begin
      if (accept && wdata[SWRST_BIT]) begin
        swrst_q <= 1'b1;
      end else if (accept) begin
        cfg_q <= cfg_apply(cfg_q, wdata);
      end
      if (wr_lock) begin
        lock_q <= wdata[LOCK_BIT];
      end
    end
  end

  AST_NO_RSVD_MODE: assert property (@(posedge clk) disable iff (rst)
    cfg_q.mode != MODE_RSVD); // R4
  AST_NO_MPU_FULLMUX: assert property (@(posedge clk) disable iff (rst)
    !(cfg_q.mode == MODE_MPU && cfg_q.mux == MUX_ALL)); // R5
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && !lock_q && !swrst_q) |=> ($stable(cfg_q) && !swrst_q)); // R2
  AST_SWRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    swrst_q |=> !swrst_q); // R6
  AST_SWRST_RESTORE: assert property (@(posedge clk) disable iff (rst)
    swrst_q |=> (cfg_q == cfg_reset($past(mode_strap)) && !lock_q)); // R6
endmodule

// File: rtl/pmode_out_decode.sv
module pmode_out_decode
  import pmode_pkg::*;
#(
  parameter int LOCK_BIT = 1
) (
  input  cfg_t       cfg_q,
  input  logic       lock_q,
  input  logic       hit_mode,
  input  logic       hit_lock,
  output logic [7:0] rdata,
  output logic [1:0] mode_o,
  output logic       strobe_style_o,
  output logic [1:0] mux_space_o,
  output logic       addr_pins_o,
  output logic       bclk_oe_o
);
  always_comb begin
    rdata = '0;
    if (hit_mode) begin
      rdata = cfg_pack(cfg_q);
    end else if (hit_lock) begin
      rdata[LOCK_BIT] = lock_q;
    end
    mode_o         = cfg_q.mode;
    strobe_style_o = cfg_q.style;
    mux_space_o    = cfg_q.mux;
    addr_pins_o    = ((cfg_q.mode == MODE_EXPAND) || (cfg_q.mode == MODE_MPU)) && !cfg_q.port_fn;
    bclk_oe_o      = !cfg_q.bclk_off;
  end
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
  import pmode_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(10),
  parameter int                LOCK_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_strap,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [1:0]        mode_o,
  output logic              strobe_style_o,
  output logic [1:0]        mux_space_o,
  output logic              addr_pins_o,
  output logic              bclk_oe_o,
  output logic              swreset_o
);
  logic wr_mode, wr_lock, hit_mode, hit_lock;
  logic lock_q, swrst_q;
  cfg_t cfg_q;

  pmode_wr_decode #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .LOCK_ADDR(LOCK_ADDR)
  ) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .wr_mode(wr_mode), .wr_lock(wr_lock), .hit_mode(hit_mode), .hit_lock(hit_lock)
  );

  pmode_field_regs #(.LOCK_BIT(LOCK_BIT)) u_regs (
    .clk(clk), .rst(rst), .mode_strap(mode_strap),
    .wr_mode(wr_mode), .wr_lock(wr_lock), .wdata(bus_wdata),
    .cfg_q(cfg_q), .lock_q(lock_q), .swrst_q(swrst_q)
  );

  pmode_out_decode #(.LOCK_BIT(LOCK_BIT)) u_out (
    .cfg_q(cfg_q), .lock_q(lock_q), .hit_mode(hit_mode), .hit_lock(hit_lock),
    .rdata(bus_rdata), .mode_o(mode_o), .strobe_style_o(strobe_style_o),
    .mux_space_o(mux_space_o), .addr_pins_o(addr_pins_o), .bclk_oe_o(bclk_oe_o)
  );

  assign swreset_o = swrst_q;

  AST_ADDR_PINS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00) |-> !addr_pins_o); // R8
  AST_BIT3_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == MODE_ADDR) |-> !bus_rdata[SWRST_BIT]); // R6
endmodule

// File: tb/pmode_ctrl_test.sv
module pmode_ctrl_test;
  localparam logic [3:0] MA = 4'h4;
  localparam logic [3:0] LA = 4'hA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_strap = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] mode_o, mux_space_o;
  logic strobe_style_o, addr_pins_o, bclk_oe_o, swreset_o;

  pmode_ctrl uut (
    .clk(clk), .rst(rst), .mode_strap(mode_strap), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_o(mode_o),
    .strobe_style_o(strobe_style_o), .mux_space_o(mux_space_o), .addr_pins_o(addr_pins_o),
    .bclk_oe_o(bclk_oe_o), .swreset_o(swreset_o)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] exp;
    logic [3:0] req;
  } item_t;

  item_t q[$];
  item_t it_m;
  logic [7:0] act_m;
  int vectors = 0;
  int errors = 0;
  bit done = 0;

  // Monitor: kind 0 read data, kind 1 output vector, kind 2 reset request
  always @(negedge clk) begin
    while (q.size() > 0) begin
      it_m = q.pop_front();
      case (it_m.kind)
        2'd0:    act_m = bus_rdata;
        2'd1:    act_m = {1'b0, mode_o, strobe_style_o, mux_space_o, addr_pins_o, bclk_oe_o};
        default: act_m = {7'b0, swreset_o};
      endcase
      vectors++;
      if (act_m !== it_m.exp) begin
        errors++;
        $display("FAIL R%0d kind %0d: actual %02h expected %02h", it_m.req, it_m.kind, act_m, it_m.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step();
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic expect_now(input logic [1:0] k, input logic [7:0] e, input logic [3:0] r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input logic [3:0] r);
    bus_addr = a; #0.5;
    expect_now(2'd0, e, r);
    settle();
  endtask

  task automatic out_chk(input logic [6:0] e, input logic [3:0] r);
    expect_now(2'd1, {1'b0, e}, r);
    settle();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset with strap low
    rd_chk(MA, 8'h00, 4'd1);
    rd_chk(LA, 8'h00, 4'd1);
    out_chk(7'b00_0_00_0_1, 4'd1);
    rd_chk(4'h7, 8'h00, 4'd3); // R3 unmapped address
    // R2: locked write ignored
    wr(MA, 8'h81);
    rd_chk(MA, 8'h00, 4'd2);
    // R3: lock stores only bit 1
    wr(LA, 8'hFF);
    rd_chk(LA, 8'h02, 4'd3);
    // R2: unlocked write lands
    wr(MA, 8'h31);
    rd_chk(MA, 8'h31, 4'd2);
    out_chk(7'b01_0_11_1_1, 4'd7); // R7
    rd_chk(LA, 8'h02, 4'd3);       // R3 lock persists
    // R4: reserved mode keeps mode, other bits land
    wr(MA, 8'h76);
    rd_chk(MA, 8'h75, 4'd4);
    out_chk(7'b01_1_11_0_1, 4'd8); // R8 port function
    // R5: full mux rejected in microprocessor mode
    wr(MA, 8'h33);
    rd_chk(MA, 8'h03, 4'd5);
    out_chk(7'b11_0_00_1_1, 4'd5);
    wr(MA, 8'h23);
    rd_chk(MA, 8'h23, 4'd5);
    // R7/R8: clock disable and port function
    wr(MA, 8'hC3);
    out_chk(7'b11_0_00_0_0, 4'd7);
    // R8: single-chip forces address pins off
    wr(MA, 8'h40);
    out_chk(7'b00_0_00_0_1, 4'd8);
    wr(MA, 8'h00);
    out_chk(7'b00_0_00_0_1, 4'd8);
    // R2: relock then write ignored
    wr(LA, 8'h00);
    rd_chk(LA, 8'h00, 4'd2);
    wr(MA, 8'h19);
    rd_chk(MA, 8'h00, 4'd2);
    expect_now(2'd2, 8'h00, 4'd2);
    settle();
    // R6: software reset pulse with strap high
    wr(LA, 8'h02);
    mode_strap = 1'b1;
    wr(MA, 8'hBD);
    bus_addr = MA; #0.5;
    expect_now(2'd2, 8'h01, 4'd6);
    expect_now(2'd0, 8'h00, 4'd6);
    settle();
    step();
    expect_now(2'd2, 8'h00, 4'd6);
    settle();
    rd_chk(MA, 8'h03, 4'd6);
    rd_chk(LA, 8'h00, 4'd6);
    // R1: hardware reset with strap high
    wr(LA, 8'h02);
    wr(MA, 8'h25);
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    rd_chk(MA, 8'h03, 4'd1);
    out_chk(7'b11_0_00_1_1, 4'd1);
    settle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule